// File: doc/BRIEF.md
# Fall-Through Strobe FIFO

This block is a first-in first-out buffer of 64 words of 4 bits, driven by two strobes rather than by read and write enables. A producer raises the write strobe to hand over the word on the data inputs; a consumer drops the read strobe to take the word on the data outputs. The oldest word moves into an output register without being asked, so it is already on the outputs, with the output-ready flag high, before the consumer takes it. An input-ready flag tells the producer when another word can be handed over.

The block runs on one system clock. The write strobe, the read strobe and the active-low reset are passed through two-flop synchronizers, and the strobes are edge-detected inside the block. Reset is applied to all internal state at once and released on the clock, two cycles later. Two corner cases are handled without extra strobes. If the read strobe is held high while the buffer is empty, a new word flashes past the outputs for one cycle and is then counted as taken. If the write strobe is held high while the buffer is full, freeing a slot makes input-ready go high for one cycle, and then the held word is taken.

Top module: `ft_fifo`

## Requirements
- R1: Words leave in the order they were accepted, with bit values unchanged, and no more than 64 words are held at once.
- R2: A word on `din` is accepted once per high period of `wr_stb`, three clock edges after `wr_stb` rises; from then on `in_rdy` stays low until `wr_stb` goes low again.
- R3: When the output register is empty, the oldest stored word moves onto `dout` with `out_rdy` high. A word that was written into an empty buffer moves only after `wr_stb` returns low. Later words queue behind it and leave `dout` unchanged.
- R4: A falling edge on `rd_stb` removes the word on `dout`, and the next stored word then moves onto `dout`. `out_rdy` is low while `rd_stb` is high.
- R5: A `rd_stb` pulse while the buffer is empty has no effect; the last word removed stays on `dout` and `out_rdy` stays low.
- R6: While 64 words are held, `in_rdy` is low and a `wr_stb` pulse that ends before a slot frees is ignored.
- R7: With `rd_stb` held high and the buffer empty, a word written by a `wr_stb` pulse appears on `dout` with `out_rdy` high for exactly one clock cycle and is then treated as removed.
- R8: With the buffer full and `wr_stb` held high, a `rd_stb` falling edge makes `in_rdy` high for exactly one clock cycle, after which the word on `din` is accepted and the buffer is full again.
- R9: While `rst_n` is low the buffer is empty, `dout` is zero, `out_rdy` is low and `in_rdy` is high.
- R10: If `wr_stb` is high when `rst_n` is released, the word on `din` is accepted and `in_rdy` stays low until `wr_stb` goes low.
- R11: If `wr_stb` goes low before `rst_n` is released, nothing is accepted: `in_rdy` stays high, `out_rdy` stays low and `dout` stays zero.
- R12: A write and a removal that are detected in the same clock cycle both take effect, and neither word is lost or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted at once and released on the clock |
| wr_stb | input | 1 | Write strobe; its rising edge hands over `din` |
| rd_stb | input | 1 | Read strobe; its falling edge takes `dout` |
| din | input | 4 | Data word to store |
| dout | output | 4 | Word at the head of the buffer |
| in_rdy | output | 1 | High when another word can be accepted |
| out_rdy | output | 1 | High when `dout` holds a word not yet taken |

## Verification
Two functions can fall in the same cycle: a write capture and the removal of the head word. A detected `wr_stb` rising edge and a detected `rd_stb` falling edge both change the occupancy and the output register. The bench provokes this by raising `wr_stb` and dropping `rd_stb` in the same half-cycle while the buffer holds two words. Both strobes pass through identical synchronizers, so the two edges are detected on the same clock. The result is judged by the order of the words read out afterwards: the removed word must be gone, and the new word must follow the word queued ahead of it.

// File: rtl/ft_fifo_pkg.sv
package ft_fifo_pkg;

    // Reset value of the control flags.
    localparam logic IN_RDY_RST  = 1'b1;
    localparam logic OUT_RDY_RST = 1'b0;

    // Occupancy width for a given depth.
    function automatic int occ_width(input int depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/ft_fifo_rst_sync.sv
module ft_fifo_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic rst_int_n
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = (chain_q << 1) | STAGES'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign rst_int_n = chain_q[STAGES-1];

endmodule

// File: rtl/ft_fifo_sync.sv
module ft_fifo_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_int_n,
    input  logic raw,
    output logic level
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = (chain_q << 1) | STAGES'(raw);
    end

    always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n) chain_q <= '0;
        else            chain_q <= chain_d;
    end

    assign level = chain_q[STAGES-1];

endmodule

// File: rtl/ft_fifo_store.sv
module ft_fifo_store #(
    parameter int WIDTH = 4,
    parameter int DEPTH = 64,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = ft_fifo_pkg::occ_width(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_int_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count
);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } store_t;

    store_t st_d, st_q;
    logic [WIDTH-1:0] mem [DEPTH];

    always_comb begin
        st_d = st_q;
        if (push) st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + AW'(1);
        if (pop)  st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + AW'(1);
        st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n) st_q <= '0;
        else            st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[st_q.wp] <= wdata;
    end

    assign rdata = mem[st_q.rp];
    assign count = st_q.cnt;

    // R1: the control never moves a word out of an empty array
    p_no_underflow_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
        pop |-> (st_q.cnt != '0));

    // R6: the control never writes into a full array
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
        (push && !pop) |-> (st_q.cnt != CW'(DEPTH)));

endmodule

// File: rtl/ft_fifo.sv
module ft_fifo #(
    parameter int WIDTH       = 4,
    parameter int DEPTH       = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic             rd_stb,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             in_rdy,
    output logic             out_rdy
);

    import ft_fifo_pkg::*;

    localparam int CW   = occ_width(DEPTH);
    localparam int NSTB = 2;

    typedef struct packed {
        logic [WIDTH-1:0] dout;
        logic             held;
        logic             taken;
        logic             rd_prev;
        logic             in_rdy;
        logic             out_rdy;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              rst_int_n;
    logic [NSTB-1:0]   raw_stb;
    logic [NSTB-1:0]   lvl_stb;
    logic              wr_lvl, rd_lvl;
    logic [WIDTH-1:0]  rdata;
    logic [CW-1:0]     count;
    logic [CW-1:0]     total, total_n;
    logic              full, rd_fall;
    logic              wr_go, rd_go, ft_go, pass_pulse;

    ft_fifo_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_int_n (rst_int_n)
    );

    assign raw_stb = {rd_stb, wr_stb};

    for (genvar g = 0; g < NSTB; g++) begin : g_stb
        ft_fifo_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk       (clk),
            .rst_int_n (rst_int_n),
            .raw       (raw_stb[g]),
            .level     (lvl_stb[g])
        );
    end

    assign wr_lvl = lvl_stb[0];
    assign rd_lvl = lvl_stb[1];

    ft_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_store (
        .clk       (clk),
        .rst_int_n (rst_int_n),
        .push      (wr_go),
        .pop       (ft_go),
        .wdata     (din),
        .rdata     (rdata),
        .count     (count)
    );

    always_comb begin
        ctl_d   = ctl_q;
        total   = count + CW'(ctl_q.held);
        full    = (total == CW'(DEPTH));
        rd_fall = !rd_lvl && ctl_q.rd_prev;

        // one capture per write-strobe high period, only with a free slot
        wr_go = wr_lvl && !ctl_q.taken && !full;
        // removal of the presented word
        rd_go = rd_fall && ctl_q.held;
        // head moves to the output stage; a word still held by the strobe waits
        ft_go = !ctl_q.held && (count != '0)
                && !(wr_lvl && ctl_q.taken && (count == CW'(1)));
        // read strobe already high: the word is shown for one cycle and taken
        pass_pulse = ft_go && rd_lvl;

        if (ft_go) begin
            ctl_d.dout = rdata;
            ctl_d.held = !rd_lvl;
        end else if (rd_go) begin
            ctl_d.held = 1'b0;
        end

        ctl_d.taken   = wr_lvl && (ctl_q.taken || wr_go);
        ctl_d.rd_prev = rd_lvl;

        total_n = total + CW'(wr_go) - CW'(rd_go) - CW'(pass_pulse);

        ctl_d.in_rdy  = (total_n != CW'(DEPTH)) && !ctl_d.taken;
        ctl_d.out_rdy = (ctl_d.held && !rd_lvl) || pass_pulse;
    end

    always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n) begin
            ctl_q         <= '0;
            ctl_q.in_rdy  <= IN_RDY_RST;
            ctl_q.out_rdy <= OUT_RDY_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign dout    = ctl_q.dout;
    assign in_rdy  = ctl_q.in_rdy;
    assign out_rdy = ctl_q.out_rdy;

    // R1: occupancy of array plus output stage never exceeds the depth
    p_occupancy_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
        (count + CW'(ctl_q.held)) <= CW'(DEPTH));

    // R2: after a capture, input-ready stays low while the strobe is high
    p_ir_low_after_capture_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
        ctl_q.taken |-> !in_rdy);

    // R4: output-ready after a high read strobe is only the pass-through pulse
    p_or_low_rd_high_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
        ($past(rd_lvl) && out_rdy) |-> !ctl_q.held);

    // R5: with nothing stored and nothing presented, the outputs keep their word
    p_dout_kept_empty_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
        ((count == '0) && !ctl_q.held) |=> $stable(dout));

    // R6: a full buffer never reports input-ready
    p_full_no_ir_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
        ((count + CW'(ctl_q.held)) == CW'(DEPTH)) |-> !in_rdy);

    // R7: the pass-through output-ready pulse lasts one cycle
    p_pass_pulse_one_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
        (out_rdy && !ctl_q.held) |=> !out_rdy);

endmodule

// File: tb/test_ft_fifo.sv
module test_ft_fifo;

    logic       clk = 1'b0;
    logic       rst_n, wr_stb, rd_stb;
    logic [3:0] din, dout;
    logic       in_rdy, out_rdy;

    int         checks = 0;
    int         errors = 0;
    int         model_cnt = 0;
    bit         done = 1'b0;
    logic [3:0] exp_q [$];

    always #10 clk = ~clk;

    ft_fifo i_ft_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .rd_stb  (rd_stb),
        .din     (din),
        .dout    (dout),
        .in_rdy  (in_rdy),
        .out_rdy (out_rdy)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver: strobe one word in and record it if the model has room
    task automatic drive_word(input logic [3:0] d);
        din    = d;
        wr_stb = 1'b1;
        tick(5);
        wr_stb = 1'b0;
        tick(5);
        if (model_cnt < 64) begin
            exp_q.push_back(d);
            model_cnt++;
        end
    endtask

    // monitor: compare the presented word with the queue head, then take it
    task automatic take_word(input string req);
        logic [3:0] e;
        e = exp_q.pop_front();
        chk({req, " out_rdy before take"}, int'(out_rdy), 1);
        chk({req, " word order"}, int'(dout), int'(e));
        rd_stb = 1'b1;
        tick(5);
        chk("R4 out_rdy low while rd_stb high", int'(out_rdy), 0);
        rd_stb = 1'b0;
        tick(5);
        model_cnt--;
    endtask

    initial begin
        int pulses;
        int seen;
        rst_n = 1'b0; wr_stb = 1'b0; rd_stb = 1'b0; din = '0;
        tick(3);
        chk("R9 in_rdy in reset", int'(in_rdy), 1);
        chk("R9 out_rdy in reset", int'(out_rdy), 0);
        chk("R9 dout in reset", int'(dout), 0);
        rst_n = 1'b1;
        tick(5);

        // R2 / R3: first word held back until the strobe drops
        din = 4'h5; wr_stb = 1'b1;
        tick(5);
        chk("R2 in_rdy low after capture", int'(in_rdy), 0);
        chk("R3 no fall-through while wr_stb high", int'(out_rdy), 0);
        wr_stb = 1'b0;
        tick(5);
        chk("R2 in_rdy back high", int'(in_rdy), 1);
        chk("R3 out_rdy after fall-through", int'(out_rdy), 1);
        chk("R3 dout after fall-through", int'(dout), 5);
        exp_q.push_back(4'h5); model_cnt = 1;

        drive_word(4'hA);
        drive_word(4'h3);
        chk("R3 later words do not disturb dout", int'(dout), 5);
        for (int k = 0; k < 3; k++) take_word("R1");

        // R5: empty buffer ignores a read strobe
        chk("R5 out_rdy when empty", int'(out_rdy), 0);
        chk("R5 last word kept", int'(dout), 3);
        rd_stb = 1'b1; tick(5); rd_stb = 1'b0; tick(5);
        chk("R5 dout after empty read", int'(dout), 3);
        chk("R5 out_rdy after empty read", int'(out_rdy), 0);

        // R6: fill to depth, extra word ignored
        for (int k = 0; k < 64; k++) drive_word(4'((k * 7 + 1) & 15));
        chk("R6 in_rdy low when full", int'(in_rdy), 0);
        drive_word(4'hE);
        chk("R6 in_rdy low after ignored write", int'(in_rdy), 0);

        // R8: automatic capture with wr_stb held high
        din = 4'h9; wr_stb = 1'b1;
        tick(5);
        chk("R8 in_rdy low before slot frees", int'(in_rdy), 0);
        chk("R8 head word", int'(dout), int'(exp_q[0]));
        rd_stb = 1'b1; tick(5); rd_stb = 1'b0;
        pulses = 0;
        for (int k = 0; k < 10; k++) begin
            tick(1);
            if (in_rdy) pulses++;
        end
        chk("R8 in_rdy pulse cycles", pulses, 1);
        void'(exp_q.pop_front());
        exp_q.push_back(4'h9);
        wr_stb = 1'b0;
        tick(5);
        chk("R8 full again after capture", int'(in_rdy), 0);
        for (int k = 0; k < 64; k++) take_word("R1");
        chk("R1 nothing beyond 64 words", int'(out_rdy), 0);

        // R7: pass-through pulse with rd_stb held high
        rd_stb = 1'b1; tick(5);
        din = 4'h6; wr_stb = 1'b1; tick(5); wr_stb = 1'b0;
        pulses = 0; seen = 0;
        for (int k = 0; k < 8; k++) begin
            tick(1);
            if (out_rdy) begin pulses++; seen = int'(dout); end
        end
        chk("R7 out_rdy pulse cycles", pulses, 1);
        chk("R7 word shown during pulse", seen, 6);
        rd_stb = 1'b0; tick(5);
        chk("R7 word treated as taken", int'(out_rdy), 0);
        chk("R7 in_rdy after pass-through", int'(in_rdy), 1);

        // R12: capture and removal detected in the same cycle
        drive_word(4'h2);
        drive_word(4'h7);
        rd_stb = 1'b1; tick(5);
        din = 4'hC; wr_stb = 1'b1; rd_stb = 1'b0;
        tick(5);
        wr_stb = 1'b0;
        tick(5);
        void'(exp_q.pop_front());
        exp_q.push_back(4'hC);
        take_word("R12");
        take_word("R12");
        chk("R12 empty afterwards", int'(out_rdy), 0);

        // R9: reset in the middle of operation
        drive_word(4'h1);
        drive_word(4'h4);
        rst_n = 1'b0;
        tick(2);
        chk("R9 dout cleared", int'(dout), 0);
        chk("R9 out_rdy cleared", int'(out_rdy), 0);
        chk("R9 in_rdy set", int'(in_rdy), 1);
        exp_q.delete(); model_cnt = 0;

        // R10: wr_stb high across reset release
        din = 4'hB; wr_stb = 1'b1;
        tick(2);
        rst_n = 1'b1;
        tick(6);
        chk("R10 in_rdy low after release capture", int'(in_rdy), 0);
        wr_stb = 1'b0;
        tick(5);
        chk("R10 in_rdy after wr_stb low", int'(in_rdy), 1);
        exp_q.push_back(4'hB); model_cnt = 1;
        take_word("R10");

        // R11: wr_stb dropped before reset release
        rst_n = 1'b0;
        din = 4'hD; wr_stb = 1'b1;
        tick(3);
        wr_stb = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(8);
        chk("R11 in_rdy high", int'(in_rdy), 1);
        chk("R11 out_rdy low", int'(out_rdy), 0);
        chk("R11 dout zero", int'(dout), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule